// File: doc/BRIEF.md
# Predicated Vector Bitwise Logic Unit

This block decodes one 32-bit instruction word and runs one of five two-operand bitwise operations on 128-bit vector registers. The operations are AND, AND with an inverted second operand, OR, OR with an inverted second operand, and XOR. The block holds eight 128-bit vector registers. An instruction names two source registers, n and m, and one destination register, d. The result is computed across all 128 bits. A 16-bit predicate then merges it into d one byte at a time. Bytes whose predicate bit is clear keep the value d already had.

The decoder compares the word against a fixed bit pattern. Words that do not match raise an encoding flag. A register field that names an index the bank does not hold raises a separate range flag. In both cases nothing is written. A load port places raw values into the bank. A read port returns any register, so the surrounding logic, or a bench, can see the results.

Top module: `vlu_top`

## Requirements
- R1: Synchronous active-high reset clears all eight registers to zero.
- R2: When `ld_valid` is high and no instruction write happens in that cycle, `ld_data` is written to register `ld_sel` on the next clock edge.
- R3: A word with bits[31:28]=4'b1110 selects an operation from bits[21:20]: 2'b00 gives n&m, 2'b01 gives n&~m, 2'b10 gives n|m, 2'b11 gives n|~m.
- R4: A word with bits[31:28]=4'b1111 and bits[21:20]=2'b00 gives n^m.
- R5: A word is accepted only if all of these hold:
  - bits[27:24]=4'b1111, bit23=0, bit16=0, bit12=0, bits[11:8]=4'b0001, bit6=1, bit4=1 and bit0=0;
  - bits[31:28] and bits[21:20] form one of the five codes above.
  Otherwise `enc_illegal` is 1 and no register changes.
- R6: The register fields are n = {bit7, bits[19:17]}, d = {bit22, bits[15:13]} and m = {bit5, bits[3:1]}.
- R7: On a matching word where any register field is 8 or more, `reg_illegal` is 1, `enc_illegal` is 0 and no register changes.
- R8: Predicate bit i selects destination byte i (bits 8i+7..8i). A set bit takes that byte from the result. A clear bit keeps the old byte of d.
- R9: `merged_q` shows the merged value for the present inputs in the same cycle. On a valid word with `exec_valid` high, this value is written to d on the next clock edge.
- R10: With `exec_valid` low, a valid word writes nothing.
- R11: When an instruction write and a load happen in the same cycle, the instruction write is performed and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | Execute the instruction word this cycle |
| instr | input | 32 | Instruction word |
| pred_mask | input | 16 | Per-byte write predicate |
| ld_valid | input | 1 | Load strobe |
| ld_sel | input | 3 | Register index to load |
| ld_data | input | 128 | Value to load |
| dbg_sel | input | 3 | Read port register index |
| dbg_data | output | 128 | Read port value |
| merged_q | output | 128 | Merged destination value for the current word |
| enc_illegal | output | 1 | Word does not match any supported encoding |
| reg_illegal | output | 1 | Word matches but a register field is out of range |

## Verification
Some properties are checked on every cycle:
- Both flags are never high together.
- A flagged word never produces a bank write.
- Bytes with a clear predicate bit in `merged_q` always equal the old destination byte, and bytes with a set bit always equal the operation result.
- The bank holds its contents whenever no write is requested.

The remaining behaviour is shown only by the bench scenarios:
- the mapping of encodings to operations and the bit positions of the register fields;
- every fixed bit being enforced;
- the precedence of an instruction write over a load.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    localparam int VEC_W   = 128;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = VEC_W / BYTE_W;
    localparam int NREGS   = 8;
    localparam int IDX_W   = $clog2(NREGS);
    localparam int FIELD_W = 4;

    // fixed-bit check of the instruction word
    localparam logic [31:0] FIX_MASK = 32'h0F81_1F51;
    localparam logic [31:0] FIX_VAL  = 32'h0F00_0150;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_ANDN = 3'd1,
        OP_OR   = 3'd2,
        OP_ORN  = 3'd3,
        OP_XOR  = 3'd4
    } logic_op_e;

    typedef struct packed {
        logic               match;
        logic               idx_bad;
        logic_op_e          op;
        logic [FIELD_W-1:0] qd;
        logic [FIELD_W-1:0] qn;
        logic [FIELD_W-1:0] qm;
    } dec_t;

    function automatic logic [VEC_W-1:0] byte_expand(input logic [NBYTES-1:0] p);
        logic [VEC_W-1:0] r;
        for (int i = 0; i < NBYTES; i++) begin
            r[i*BYTE_W +: BYTE_W] = {BYTE_W{p[i]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/vlu_decode.sv
module vlu_decode
    import vlu_pkg::*;
#(
    parameter int N_REGS = NREGS
) (
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic       fixed_ok;
    logic [3:0] top;
    logic [1:0] sel;
    logic       code_ok;
    logic_op_e  op_c;

    assign fixed_ok = (instr & FIX_MASK) == FIX_VAL;
    assign top      = instr[31:28];
    assign sel      = instr[21:20];

    always_comb begin
        code_ok = 1'b0;
        op_c    = OP_AND;
        if (top == 4'b1110) begin
            code_ok = 1'b1;
            unique case (sel)
                2'b00:   op_c = OP_AND;
                2'b01:   op_c = OP_ANDN;
                2'b10:   op_c = OP_OR;
                default: op_c = OP_ORN;
            endcase
        end else if (top == 4'b1111 && sel == 2'b00) begin
            code_ok = 1'b1;
            op_c    = OP_XOR;
        end
    end

    always_comb begin
        dec.match   = fixed_ok && code_ok;
        dec.op      = op_c;
        dec.qn      = {instr[7],  instr[19:17]};
        dec.qd      = {instr[22], instr[15:13]};
        dec.qm      = {instr[5],  instr[3:1]};
        dec.idx_bad = dec.match &&
                      ((int'(dec.qn) >= N_REGS) ||
                       (int'(dec.qd) >= N_REGS) ||
                       (int'(dec.qm) >= N_REGS));
    end

endmodule

// File: rtl/vlu_alu.sv
module vlu_alu
    import vlu_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  logic_op_e      op,
    input  logic [W-1:0]   n,
    input  logic [W-1:0]   m,
    output logic [W-1:0]   y
);
    logic [W-1:0] m_eff;
    logic         inv_m;

    assign inv_m = (op == OP_ANDN) || (op == OP_ORN);
    assign m_eff = inv_m ? ~m : m;

    always_comb begin
        unique case (op)
            OP_AND, OP_ANDN: y = n & m_eff;
            OP_OR,  OP_ORN:  y = n | m_eff;
            OP_XOR:          y = n ^ m;
            default:         y = '0;
        endcase
    end

endmodule

// File: rtl/vlu_merge.sv
module vlu_merge
    import vlu_pkg::*;
#(
    parameter int NB = NBYTES,
    parameter int BW = BYTE_W
) (
    input  logic [NB-1:0]    pred,
    input  logic [NB*BW-1:0] res,
    input  logic [NB*BW-1:0] old,
    output logic [NB*BW-1:0] y
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign y[i*BW +: BW] = pred[i] ? res[i*BW +: BW] : old[i*BW +: BW];
    end
endmodule

// File: rtl/vlu_regbank.sv
module vlu_regbank
    import vlu_pkg::*;
#(
    parameter int N = NREGS,
    parameter int W = VEC_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_a_idx,
    input  logic [IW-1:0] rd_b_idx,
    input  logic [IW-1:0] rd_c_idx,
    input  logic [IW-1:0] dbg_idx,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_c,
    output logic [W-1:0]  dbg
);
    logic [N-1:0][W-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];
    assign rd_c = mem[rd_c_idx];
    assign dbg  = mem[dbg_idx];

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !wr_en) |=> $stable(mem)); // R10
    AST_BANK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en) |=> mem[$past(wr_idx)] == $past(wr_data)); // R9

endmodule

// File: rtl/vlu_top.sv
module vlu_top
    import vlu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               exec_valid,
    input  logic [31:0]        instr,
    input  logic [NBYTES-1:0]  pred_mask,
    input  logic               ld_valid,
    input  logic [IDX_W-1:0]   ld_sel,
    input  logic [VEC_W-1:0]   ld_data,
    input  logic [IDX_W-1:0]   dbg_sel,
    output logic [VEC_W-1:0]   dbg_data,
    output logic [VEC_W-1:0]   merged_q,
    output logic               enc_illegal,
    output logic               reg_illegal
);
    dec_t             dec;
    logic [VEC_W-1:0] n_val, m_val, d_old, alu_y;
    logic             exec_wr;
    logic             bank_we;
    logic [IDX_W-1:0] bank_idx;
    logic [VEC_W-1:0] bank_data;

    vlu_decode #(.N_REGS(NREGS)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    vlu_regbank #(.N(NREGS), .W(VEC_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bank_we),
        .wr_idx   (bank_idx),
        .wr_data  (bank_data),
        .rd_a_idx (dec.qn[IDX_W-1:0]),
        .rd_b_idx (dec.qm[IDX_W-1:0]),
        .rd_c_idx (dec.qd[IDX_W-1:0]),
        .dbg_idx  (dbg_sel),
        .rd_a     (n_val),
        .rd_b     (m_val),
        .rd_c     (d_old),
        .dbg      (dbg_data)
    );

    vlu_alu #(.W(VEC_W)) u_alu (
        .op (dec.op),
        .n  (n_val),
        .m  (m_val),
        .y  (alu_y)
    );

    vlu_merge #(.NB(NBYTES), .BW(BYTE_W)) u_merge (
        .pred (pred_mask),
        .res  (alu_y),
        .old  (d_old),
        .y    (merged_q)
    );

    assign enc_illegal = !dec.match;
    assign reg_illegal = dec.idx_bad;
    assign exec_wr     = exec_valid && dec.match && !dec.idx_bad;
    assign bank_we     = exec_wr || ld_valid;
    assign bank_idx    = exec_wr ? dec.qd[IDX_W-1:0] : ld_sel;
    assign bank_data   = exec_wr ? merged_q : ld_data;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({enc_illegal, reg_illegal})); // R7
    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        ((enc_illegal || reg_illegal) && !ld_valid) |-> !bank_we); // R5
    AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (rst)
        ((merged_q ^ d_old) & ~byte_expand(pred_mask)) == '0); // R8
    AST_MERGE_TAKE: assert property (@(posedge clk) disable iff (rst)
        ((merged_q ^ alu_y) & byte_expand(pred_mask)) == '0); // R8

endmodule

// File: tb/vlu_top_bench.sv
module vlu_top_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         exec_valid;
    logic [31:0]  instr;
    logic [15:0]  pred_mask;
    logic         ld_valid;
    logic [2:0]   ld_sel;
    logic [127:0] ld_data;
    logic [2:0]   dbg_sel;
    logic [127:0] dbg_data;
    logic [127:0] merged_q;
    logic         enc_illegal;
    logic         reg_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [127:0] model [8];

    vlu_top u_vlu_top (
        .clk(clk), .rst(rst), .exec_valid(exec_valid), .instr(instr),
        .pred_mask(pred_mask), .ld_valid(ld_valid), .ld_sel(ld_sel),
        .ld_data(ld_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .merged_q(merged_q), .enc_illegal(enc_illegal), .reg_illegal(reg_illegal)
    );

    always #4 clk = ~clk;

    // stimulus: {xor_top, sel[1:0], qd[3:0], qn[3:0], qm[3:0], pred[15:0]}
    localparam logic [30:0] VECS [10] = '{
        {1'b0, 2'b00, 4'd2, 4'd0, 4'd1, 16'hFFFF},
        {1'b0, 2'b01, 4'd3, 4'd0, 4'd1, 16'hFFFF},
        {1'b0, 2'b10, 4'd4, 4'd0, 4'd1, 16'h00FF},
        {1'b0, 2'b11, 4'd5, 4'd1, 4'd0, 16'hF0F0},
        {1'b1, 2'b00, 4'd6, 4'd2, 4'd3, 16'hFFFF},
        {1'b1, 2'b00, 4'd7, 4'd7, 4'd7, 16'hA5A5},
        {1'b0, 2'b00, 4'd0, 4'd5, 4'd6, 16'h0001},
        {1'b0, 2'b10, 4'd1, 4'd6, 4'd7, 16'h8000},
        {1'b0, 2'b11, 4'd2, 4'd2, 4'd2, 16'h0000},
        {1'b0, 2'b01, 4'd3, 4'd4, 4'd5, 16'h5A5A}
    };
    localparam int FIXB [14] = '{27, 26, 25, 24, 23, 16, 12, 11, 10, 9, 8, 6, 4, 0};

    function automatic logic [31:0] mk(input logic xt, input logic [1:0] s,
                                       input logic [3:0] d, input logic [3:0] n,
                                       input logic [3:0] m);
        logic [31:0] w;
        w = '0;
        w[31:28] = xt ? 4'b1111 : 4'b1110;
        w[27:24] = 4'b1111;
        w[22]    = d[3];
        w[21:20] = s;
        w[19:17] = n[2:0];
        w[15:13] = d[2:0];
        w[11:8]  = 4'b0001;
        w[7]     = n[3];
        w[6]     = 1'b1;
        w[5]     = m[3];
        w[4]     = 1'b1;
        w[3:1]   = m[2:0];
        return w;
    endfunction

    function automatic logic [127:0] ref_op(input logic xt, input logic [1:0] s,
                                            input logic [127:0] n, input logic [127:0] m);
        if (xt) return n ^ m;
        case (s)
            2'b00:   return n & m;
            2'b01:   return n & ~m;
            2'b10:   return n | m;
            default: return n | ~m;
        endcase
    endfunction

    function automatic logic [127:0] ref_merge(input logic [15:0] p,
                                               input logic [127:0] r, input logic [127:0] o);
        logic [127:0] y;
        for (int i = 0; i < 16; i++) y[i*8 +: 8] = p[i] ? r[i*8 +: 8] : o[i*8 +: 8];
        return y;
    endfunction

    function automatic logic [127:0] pat(input int i);
        return {32'h13579BDF * (i + 1), 32'h2468ACE0 ^ i, 32'hDEADBEEF + i * 7, 32'h0F0F55AA << i};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int r = 0; r < 8; r++) begin
            dbg_sel = r[2:0];
            #1;
            chk(req, dbg_data, model[r]);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic try_bad(input string req, input logic [31:0] w,
                           input logic exp_enc, input logic exp_reg);
        instr = w; exec_valid = 1'b1; pred_mask = 16'hFFFF;
        #1;
        chk(req, {127'd0, enc_illegal}, {127'd0, exp_enc});
        chk(req, {127'd0, reg_illegal}, {127'd0, exp_reg});
        step();
        exec_valid = 1'b0;
        chk_all(req);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; exec_valid = 1'b0; instr = '0; pred_mask = '0;
        ld_valid = 1'b0; ld_sel = '0; ld_data = '0; dbg_sel = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 8; r++) model[r] = '0;
        chk_all("R1");

        // R2: load every register
        for (int r = 0; r < 8; r++) begin
            ld_valid = 1'b1; ld_sel = r[2:0]; ld_data = pat(r);
            step();
            model[r] = pat(r);
        end
        ld_valid = 1'b0;
        chk_all("R2");

        // R3 R4 R6 R8 R9: table walk
        for (int v = 0; v < 10; v++) begin
            logic xt; logic [1:0] s; logic [3:0] d, n, m; logic [15:0] p;
            logic [127:0] exp;
            {xt, s, d, n, m, p} = VECS[v];
            instr = mk(xt, s, d, n, m); pred_mask = p; exec_valid = 1'b1;
            exp = ref_merge(p, ref_op(xt, s, model[n[2:0]], model[m[2:0]]), model[d[2:0]]);
            #1;
            chk(xt ? "R4" : "R3", merged_q, exp);
            step();
            exec_valid = 1'b0;
            model[d[2:0]] = exp;
            dbg_sel = d[2:0];
            #1;
            chk("R9", dbg_data, exp);
        end
        chk_all("R8");

        // R5: every fixed bit flipped
        for (int b = 0; b < 14; b++) begin
            logic [31:0] w;
            w = mk(1'b0, 2'b10, 4'd1, 4'd2, 4'd3);
            w[FIXB[b]] = ~w[FIXB[b]];
            try_bad("R5", w, 1'b1, 1'b0);
        end
        try_bad("R5", mk(1'b1, 2'b01, 4'd1, 4'd2, 4'd3), 1'b1, 1'b0);
        try_bad("R5", mk(1'b1, 2'b11, 4'd1, 4'd2, 4'd3), 1'b1, 1'b0);
        begin
            logic [31:0] w;
            w = mk(1'b0, 2'b00, 4'd1, 4'd2, 4'd3);
            w[31:28] = 4'b1100;
            try_bad("R5", w, 1'b1, 1'b0);
        end

        // R7 R6: high bit of each register field
        try_bad("R7", mk(1'b0, 2'b00, 4'd9, 4'd2, 4'd3), 1'b0, 1'b1);
        try_bad("R7", mk(1'b0, 2'b00, 4'd1, 4'd10, 4'd3), 1'b0, 1'b1);
        try_bad("R7", mk(1'b1, 2'b00, 4'd1, 4'd2, 4'd15), 1'b0, 1'b1);

        // R10: valid word without exec_valid
        instr = mk(1'b1, 2'b00, 4'd4, 4'd0, 4'd1); pred_mask = 16'hFFFF; exec_valid = 1'b0;
        step();
        chk_all("R10");

        // R11: instruction write and load together
        instr = mk(1'b0, 2'b10, 4'd5, 4'd0, 4'd1); pred_mask = 16'hFFFF; exec_valid = 1'b1;
        ld_valid = 1'b1; ld_sel = 3'd6; ld_data = {4{32'hCAFEF00D}};
        model[5] = model[0] | model[1];
        step();
        exec_valid = 1'b0; ld_valid = 1'b0;
        chk_all("R11");

        // R1: reset after activity
        rst = 1'b1;
        step();
        rst = 1'b0;
        for (int r = 0; r < 8; r++) model[r] = '0;
        chk_all("R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule